// File: doc/BRIEF.md
# Scanline Register Table Sequencer

This block walks a table held in a byte-wide memory and, once per horizontal blanking interval, pushes register values onto a small peripheral write bus. Each table entry opens with a header byte. Bit 7 of the header selects repeat mode, and bits 6..0 give a scanline count. The payload follows the header. A transfer-pattern code fixes how many bytes make up one data set and which destination offsets those bytes go to.

A frame-start pulse reloads the table pointer from a base address. The first hblank after that pulse fetches the first header and transfers its data. In a non-repeat entry the block writes one data set and then stays quiet for the rest of the entry's count. In a repeat entry it writes a fresh data set on every scanline of the count. A header whose count field is zero ends the table until the next frame start.

The memory read port is combinational: `mem_rdata` must show the byte at `mem_addr` in the same cycle.

Top module: `hblank_table_seq`

## Requirements
- R1: After reset, `wr_en` and `busy` are low, and hblank pulses cause no writes until the first `frame_start`.
- R2: In the cycle after a `frame_start` pulse, `mem_addr` equals `base_addr`. The next hblank reads the header byte at that address.
- R3: A header whose bits 6..0 are zero (0x00 or 0x80) ends the table. No writes occur on any later hblank until the next `frame_start`.
- R4: The pattern code sets the offset sequence. Code 0 gives {0}, code 1 gives {0,1}, code 2 gives {0,0}, code 3 gives {0,0,1,1}, code 4 gives {0,1,2,3}, and codes 5, 6 and 7 behave as code 0.
- R5: The bytes of one data set go out on consecutive clocks. Each strobe lasts one clock, each byte is read from the next table address in turn, and `busy` is high on every strobe cycle.
- R6: A non-repeat entry (bit 7 clear, count N) writes its set in the first hblank only. The entry takes set length + 1 table bytes, and the next header is read on hblank N+1. N = 127 is the largest span.
- R7: A repeat entry (bit 7 set, count N) writes a new data set in each of N hblanks. It takes 1 + N × set length table bytes, and the next header is read on hblank N+1.
- R8: The pattern code is captured when a header is read. Changing it during an entry does not alter that entry's set length or offsets.
- R9: A `frame_start` in the middle of the table abandons the current entry and restarts the walk from `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that restarts the table walk |
| hblank | input | 1 | One-cycle pulse at the start of each horizontal blanking interval |
| base_addr | input | AW | Table start address, sampled on `frame_start` |
| pattern | input | 3 | Transfer-pattern code, sampled when a header is read |
| mem_addr | output | AW | Table read address |
| mem_rdata | input | 8 | Table byte at `mem_addr`, same cycle |
| wr_offset | output | 2 | Destination offset of the current write |
| wr_data | output | 8 | Data byte of the current write |
| wr_en | output | 1 | Write strobe, one clock per byte |
| busy | output | 1 | High while a data set is being issued |

## Verification
Every pattern code, including the three aliases of code 0, is run through the same two-entry table: a non-repeat entry followed by a repeat entry and a terminator. This separates the offset sequences and set lengths from one another, and shows that quiet lines and per-line sets are told apart. A 127-line non-repeat entry probes the widest count and the re-fetch on line 128. A table that opens with 0x80 checks that a zero count field terminates even with the repeat bit set. Separate runs change the pattern during a repeat entry and pulse frame start in mid-table, which tests header-time capture of the pattern and restart from the base address.

// File: rtl/tblseq_pkg.sv
package tblseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    localparam int unsigned HDR_CNT_W = 7;
    localparam int unsigned SET_MAX   = 4;
    localparam int unsigned IDX_W     = $clog2(SET_MAX);
    localparam int unsigned LEN_W     = $clog2(SET_MAX + 1);

endpackage

// File: rtl/tblseq_pattern_decode.sv
module tblseq_pattern_decode
    import tblseq_pkg::*;
(
    input  logic [2:0]       pat,
    input  logic [IDX_W-1:0] idx,
    output logic [LEN_W-1:0] set_len,
    output logic [1:0]       offset
);

    always_comb begin
        set_len = LEN_W'(1);
        offset  = 2'd0;
        case (pat)
            3'd1: begin
                set_len = LEN_W'(2);
                offset  = {1'b0, idx[0]};
            end
            3'd2: begin
                set_len = LEN_W'(2);
                offset  = 2'd0;
            end
            3'd3: begin
                set_len = LEN_W'(4);
                offset  = {1'b0, idx[1]};
            end
            3'd4: begin
                set_len = LEN_W'(4);
                offset  = idx[1:0];
            end
            default: begin
                set_len = LEN_W'(1);
                offset  = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/tblseq_line_counter.sv
module tblseq_line_counter #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == CW'(1));

    // R6 / R7: a line is only counted off an entry that still has lines left
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

    // R6: a loaded count is never zero (zero counts terminate instead)
    p_load_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

endmodule

// File: rtl/hblank_table_seq.sv
module hblank_table_seq
    import tblseq_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          hblank,
    input  logic [AW-1:0] base_addr,
    input  logic [2:0]    pattern,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic [1:0]    wr_offset,
    output logic [7:0]    wr_data,
    output logic          wr_en,
    output logic          busy
);

    localparam int unsigned CW = HDR_CNT_W;

    typedef struct packed {
        seq_state_e      state;
        logic [AW-1:0]   ptr;
        logic [IDX_W-1:0] idx;
        logic [2:0]      pat;
        logic            rep;
        logic            need_hdr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             lc_clr, lc_load, lc_dec, lc_last;
    logic [CW-1:0]    lc_val, lc_cnt;
    logic [LEN_W-1:0] set_len;
    logic [1:0]       dec_off;
    logic             set_end;

    tblseq_pattern_decode u_decode (
        .pat     (r_q.pat),
        .idx     (r_q.idx),
        .set_len (set_len),
        .offset  (dec_off)
    );

    tblseq_line_counter #(.CW(CW)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (lc_clr),
        .load     (lc_load),
        .load_val (lc_val),
        .dec      (lc_dec),
        .cnt      (lc_cnt),
        .last     (lc_last)
    );

    assign set_end = ({1'b0, r_q.idx} == (set_len - LEN_W'(1)));

    always_comb begin
        r_d     = r_q;
        lc_clr  = 1'b0;
        lc_load = 1'b0;
        lc_dec  = 1'b0;
        lc_val  = mem_rdata[CW-1:0];

        case (r_q.state)
            ST_WAIT: begin
                if (hblank) begin
                    if (r_q.need_hdr) begin
                        if (mem_rdata[CW-1:0] == '0) begin
                            r_d.state = ST_DONE;
                        end else begin
                            lc_load      = 1'b1;
                            r_d.rep      = mem_rdata[7];
                            r_d.pat      = pattern;
                            r_d.ptr      = r_q.ptr + AW'(1);
                            r_d.idx      = '0;
                            r_d.need_hdr = 1'b0;
                            r_d.state    = ST_XFER;
                        end
                    end else if (r_q.rep) begin
                        r_d.idx   = '0;
                        r_d.state = ST_XFER;
                    end else begin
                        lc_dec = 1'b1;
                        if (lc_last) begin
                            r_d.need_hdr = 1'b1;
                        end
                    end
                end
            end
            ST_XFER: begin
                r_d.ptr = r_q.ptr + AW'(1);
                if (set_end) begin
                    r_d.state = ST_WAIT;
                    lc_dec    = 1'b1;
                    if (lc_last) begin
                        r_d.need_hdr = 1'b1;
                    end
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            default: begin
                r_d = r_q;
            end
        endcase

        if (frame_start) begin
            r_d.state    = ST_WAIT;
            r_d.ptr      = base_addr;
            r_d.need_hdr = 1'b1;
            r_d.idx      = '0;
            lc_clr       = 1'b1;
            lc_load      = 1'b0;
            lc_dec       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.ptr      <= '0;
            r_q.idx      <= '0;
            r_q.pat      <= '0;
            r_q.rep      <= 1'b0;
            r_q.need_hdr <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.ptr;
    assign wr_en     = (r_q.state == ST_XFER);
    assign busy      = (r_q.state == ST_XFER);
    assign wr_data   = mem_rdata;
    assign wr_offset = dec_off;

    // R2: the pointer reloads from the base on a frame pulse
    p_frame_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mem_addr == $past(base_addr)));

    // R5: each strobe consumes exactly one table byte
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !frame_start) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    // R3: a terminated table stays silent until a frame pulse
    p_term_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DONE && !frame_start) |=> !wr_en);

    // R1: before the first frame pulse nothing is written
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !frame_start) |=> !wr_en);

    // R5: a data set only starts on an hblank
    p_start_on_hblank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && !hblank) |=> !wr_en);

endmodule

// File: tb/hblank_table_seq_test.sv
module hblank_table_seq_test;

    localparam int AW = 16;

    // per pattern code: set length, then offsets of bytes 0..3 (R4)
    localparam logic [10:0] PAT_VEC [0:7] = '{
        {3'd1, 2'd0, 2'd0, 2'd0, 2'd0},
        {3'd2, 2'd0, 2'd1, 2'd0, 2'd0},
        {3'd2, 2'd0, 2'd0, 2'd0, 2'd0},
        {3'd4, 2'd0, 2'd0, 2'd1, 2'd1},
        {3'd4, 2'd0, 2'd1, 2'd2, 2'd3},
        {3'd1, 2'd0, 2'd0, 2'd0, 2'd0},
        {3'd1, 2'd0, 2'd0, 2'd0, 2'd0},
        {3'd1, 2'd0, 2'd0, 2'd0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          hblank = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [2:0]    pattern = 3'd0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic [1:0]    wr_offset;
    logic [7:0]    wr_data;
    logic          wr_en;
    logic          busy;

    logic [7:0] mem [0:255];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    hblank_table_seq #(.AW(AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .hblank      (hblank),
        .base_addr   (base_addr),
        .pattern     (pattern),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .wr_offset   (wr_offset),
        .wr_data     (wr_data),
        .wr_en       (wr_en),
        .busy        (busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // write log
    int         log_n = 0;
    logic [1:0] log_off [0:7];
    logic [7:0] log_dat [0:7];
    int         log_cyc [0:7];
    logic       log_busy [0:7];

    always @(negedge clk) begin
        if (wr_en === 1'b1) begin
            if (log_n < 8) begin
                log_off[log_n]  = wr_offset;
                log_dat[log_n]  = wr_data;
                log_cyc[log_n]  = cyc;
                log_busy[log_n] = busy;
            end
            log_n = log_n + 1;
        end
    end

    // bench model state
    bit         m_started = 0;
    bit         m_need = 1;
    bit         m_done = 0;
    bit         m_rep = 0;
    int         m_cnt = 0;
    int         m_ptr = 0;
    logic [2:0] m_pat = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_line(input string req);
        int         exp_n;
        logic [1:0] exp_off [0:3];
        logic [7:0] exp_dat [0:3];
        bit         xfer;
        bit         work;
        logic [7:0] hdr;
        int         len;
        exp_n = 0;
        xfer  = 0;
        work  = 0;
        if (m_started && !m_done) begin
            if (m_need) begin
                hdr = mem[m_ptr[7:0]];
                if (hdr[6:0] == 7'd0) begin
                    m_done = 1;
                end else begin
                    m_cnt  = int'(hdr[6:0]);
                    m_rep  = hdr[7];
                    m_pat  = pattern;
                    m_need = 0;
                    m_ptr  = m_ptr + 1;
                    xfer   = 1;
                    work   = 1;
                end
            end else begin
                xfer = m_rep;
                work = 1;
            end
        end
        if (xfer) begin
            len = int'(PAT_VEC[m_pat][10:8]);
            for (int i = 0; i < len; i++) begin
                exp_dat[i] = mem[m_ptr[7:0]];
                exp_off[i] = PAT_VEC[m_pat][7 - 2*i -: 2];
                m_ptr = m_ptr + 1;
            end
            exp_n = len;
        end
        if (work) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_need = 1;
        end
        log_n = 0;
        @(negedge clk) hblank = 1'b1;
        @(negedge clk) hblank = 1'b0;
        repeat (7) @(negedge clk);
        check(log_n == exp_n, {req, " write count"}, log_n, exp_n);
        if (log_n == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                check(log_off[i] == exp_off[i], {req, " R4 offset"}, int'(log_off[i]), int'(exp_off[i]));
                check(log_dat[i] == exp_dat[i], {req, " R5 data"}, int'(log_dat[i]), int'(exp_dat[i]));
                check(log_cyc[i] == log_cyc[0] + i, {req, " R5 consecutive"}, log_cyc[i], log_cyc[0] + i);
                check(log_busy[i] == 1'b1, {req, " R5 busy"}, int'(log_busy[i]), 1);
            end
        end
    endtask

    task automatic start_frame(input int base);
        base_addr = AW'(base);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        check(mem_addr == AW'(base), "R2 pointer reload", int'(mem_addr), base);
        m_started = 1;
        m_need    = 1;
        m_done    = 0;
        m_ptr     = base;
    endtask

    task automatic fill_mem();
        for (int k = 0; k < 256; k++) mem[k] = 8'((k * 7 + 3) & 255);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int len;
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and no activity before a frame pulse
        check(wr_en == 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        run_line("R1 hblank before frame");
        run_line("R1 second hblank before frame");

        // vector loop over every pattern code: non-repeat 2, repeat 2, end
        for (int p = 0; p < 8; p++) begin
            fill_mem();
            len = int'(PAT_VEC[p][10:8]);
            mem[8'h20]              = 8'h02;
            mem[8'h21 + len]        = 8'h82;
            mem[8'h22 + 3 * len]    = 8'h00;
            pattern = 3'(p);
            start_frame(32'h20);
            run_line("R6 non-repeat first line");
            run_line("R6 non-repeat quiet line");
            run_line("R7 repeat line 1");
            run_line("R7 repeat line 2");
            run_line("R3 terminator");
            run_line("R3 after terminator");
        end

        // R6: widest non-repeat span, pattern 2
        fill_mem();
        mem[8'h40] = 8'd127;
        mem[8'h43] = 8'h01;
        mem[8'h46] = 8'h80;
        pattern = 3'd2;
        start_frame(32'h40);
        for (int l = 0; l < 130; l++) run_line("R6 127-line entry");

        // R3: 0x80 header terminates at once
        fill_mem();
        mem[8'h90] = 8'h80;
        pattern = 3'd1;
        start_frame(32'h90);
        run_line("R3 0x80 header");
        run_line("R3 0x80 header later");
        check(mem_addr == AW'(8'h90), "R3 pointer holds", int'(mem_addr), 8'h90);

        // R8: pattern change inside a repeat entry
        fill_mem();
        mem[8'h60] = 8'h83;
        mem[8'h6D] = 8'h00;
        pattern = 3'd4;
        start_frame(32'h60);
        run_line("R8 first set");
        pattern = 3'd1;
        run_line("R8 pattern changed");
        pattern = 3'd0;
        run_line("R8 third set");
        run_line("R8 terminator");

        // R9: restart in mid-table
        fill_mem();
        mem[8'h20] = 8'h02;
        mem[8'h23] = 8'h82;
        mem[8'h28] = 8'h00;
        pattern = 3'd1;
        start_frame(32'h20);
        run_line("R9 first line");
        run_line("R9 second line");
        run_line("R9 repeat line");
        start_frame(32'h20);
        run_line("R9 after restart");
        run_line("R9 quiet after restart");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule